// File: doc/BRIEF.md
# Octave-Extended Phase Accumulator Square-Wave Source

This block is a numerically controlled square-wave source. A phase accumulator, clocked by the master clock, adds a tuning word every cycle. The most significant bit of the phase stands in for a comparator output and forms a base clock. The tuning word is held to a 2:1 band, so the base clock runs between one eighth and one quarter of the master clock. Lower output frequencies come from a power-of-two divider. The divider is clocked by the base clock itself, so every output edge keeps the edge timing of the accumulator.

A single request loads a new tuning word and a new octave setting together. The request waits in shadow registers. An output period starts when the divider counter wraps to zero. That wrap crosses into the master domain through a two-flop synchroniser, and the tuning word and the octave setting commit on the same master cycle. The divider takes up the new octave only at its next wrap, so no output period is cut short or stretched. A busy flag covers the whole wait, and any request made while it is high is dropped.

Top module: `dds_octave_gen`

## Requirements
- R1: After reset the phase is 0, the active tuning word is 2^(PHASE_W-3) and the octave is 0. On every master clock edge the phase adds the active tuning word modulo 2^PHASE_W, and `dds_clk` is bit PHASE_W-1 of the registered phase.
- R2: A requested tuning word below 2^(PHASE_W-3) is replaced by 2^(PHASE_W-3), and one above 2^(PHASE_W-2) is replaced by 2^(PHASE_W-2). Words in between are used unchanged.
- R3: With active octave N, every period of `sq_out` spans exactly 2^N rising edges of `dds_clk`, and `sq_out` rises on a rising edge of `dds_clk`. When N is 0, `sq_out` equals `dds_clk`.
- R4: With active octave N of 1 or more, `sq_out` stays high for the first 2^(N-1) periods of `dds_clk` in each output period and low for the rest.
- R5: When `upd_req` is high at a clock edge and `busy` is low, `tune_word` and `octave` are captured, and `busy` is high from that edge on.
- R6: A request made while `busy` is high has no effect on the captured values or on the later output.
- R7: The commit takes place exactly 3 master edges after the edge on which `sq_out` rose. It uses the first such rise that is no more than 2 edges before the accepting edge. At the commit, `busy` falls, and the new tuning word drives the phase from the next edge.
- R8: The new octave first applies to the output period that begins at the first rise of `sq_out` after the commit. Every output period is a whole period of either the old or the new octave.
- R9: While reset is asserted, `busy` and `sq_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req | input | 1 | Request to load a new tuning word and octave |
| tune_word | input | PHASE_W | Requested phase increment per master cycle |
| octave | input | OCT_W | Requested power-of-two division exponent N |
| busy | output | 1 | High from an accepted request until its commit |
| dds_clk | output | 1 | Phase MSB; base clock for the divider |
| sq_out | output | 1 | Divided square-wave output |

## Verification
Two things can meet in the same master cycle: a request being accepted and the synchronised wrap pulse arriving. Several wrap events can also sit in flight just before a request lands. The bench issues requests at delays that step through every cycle offset relative to the output edges. A request accepted on the cycle the pulse is seen must wait for the following wrap, and a request accepted up to two edges after a wrap must commit on that wrap. In both cases the bench judges the result from the cycle `busy` falls relative to the last `sq_out` rise, and from the output period at which the new ratio shows up. One request is also made while busy, to show that it changes neither the phase stepping nor the period lengths.

// File: rtl/dds_octave_pkg.sv
package dds_octave_pkg;
  localparam int unsigned DEF_PHASE_W = 24;
  localparam int unsigned DEF_OCT_W   = 4;
  localparam int unsigned SYNC_FLOPS  = 2;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_octave_pkg::*;
#(
  parameter int unsigned PHASE_W = DEF_PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] step_word,
  output logic               msb_out
);
  localparam logic [PHASE_W-1:0] BAND_LO = {3'b001, {(PHASE_W-3){1'b0}}};
  localparam logic [PHASE_W-1:0] BAND_HI = {3'b010, {(PHASE_W-3){1'b0}}};

  logic [PHASE_W-1:0] phase_q;

  function automatic logic [PHASE_W-1:0] advance(input logic [PHASE_W-1:0] ph,
                                                 input logic [PHASE_W-1:0] st);
    return ph + st;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= advance(phase_q, step_word);
  end

  assign msb_out = phase_q[PHASE_W-1];

  // R2: the word reaching the accumulator always lies in the 2:1 band
  assert_step_in_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_word >= BAND_LO) && (step_word <= BAND_HI))
    else $error("step word outside band");
endmodule

// File: rtl/dds_octave_div.sv
module dds_octave_div
  import dds_octave_pkg::*;
#(
  parameter int unsigned OCT_W = DEF_OCT_W
) (
  input  logic             base_clk,
  input  logic             rst_n,
  input  logic [OCT_W-1:0] oct_req,
  output logic             div_out,
  output logic             wrap_flip
);
  localparam int unsigned CNT_W = 1 << OCT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [OCT_W-1:0] oct_q;
  logic [CNT_W-1:0] span_lim;
  logic             at_end;
  logic             flip_q;

  function automatic logic [CNT_W-1:0] lim_of(input logic [OCT_W-1:0] n);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic pick_out(input logic [CNT_W-1:0] c,
                                    input logic [OCT_W-1:0] n,
                                    input logic base);
    if (n == '0) return base;
    return ~c[n - OCT_W'(1)];
  endfunction

  assign span_lim = lim_of(oct_q);
  assign at_end   = ((cnt_q & span_lim) == span_lim);

  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      oct_q  <= '0;
      flip_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      oct_q  <= oct_req;
      flip_q <= ~flip_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign div_out   = pick_out(cnt_q, oct_q, base_clk);
  assign wrap_flip = flip_q;

  // R3: the count never leaves the span of the active ratio
  assert_cnt_in_span_R3: assert property (@(posedge base_clk) disable iff (!rst_n)
    (cnt_q & ~span_lim) == '0)
    else $error("divider count outside span");

  // R8: the ratio only changes at the start of an output period
  assert_oct_at_wrap_R8: assert property (@(posedge base_clk) disable iff (!rst_n)
    !$stable(oct_q) |-> (cnt_q == '0))
    else $error("octave changed mid-period");
endmodule

// File: rtl/dds_wrap_sync.sv
module dds_wrap_sync
  import dds_octave_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_FLOPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_in,
  output logic wrap_evt
);
  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= flip_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign wrap_evt = chain_q[STAGES] ^ chain_q[STAGES-1];

  // R7: wraps are at least four master cycles apart, so the pulse is single
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !wrap_evt)
    else $error("wrap pulse held two cycles");
endmodule

// File: rtl/dds_update_ctrl.sv
module dds_update_ctrl
  import dds_octave_pkg::*;
#(
  parameter int unsigned PHASE_W = DEF_PHASE_W,
  parameter int unsigned OCT_W   = DEF_OCT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [PHASE_W-1:0] req_word,
  input  logic [OCT_W-1:0]   req_oct,
  input  logic               wrap_evt,
  output logic               busy,
  output logic [PHASE_W-1:0] live_word,
  output logic [OCT_W-1:0]   live_oct
);
  localparam logic [PHASE_W-1:0] BAND_LO = {3'b001, {(PHASE_W-3){1'b0}}};
  localparam logic [PHASE_W-1:0] BAND_HI = {3'b010, {(PHASE_W-3){1'b0}}};

  logic [PHASE_W-1:0] shad_word;
  logic [OCT_W-1:0]   shad_oct;
  logic               accept;
  logic               commit;

  function automatic logic [PHASE_W-1:0] fit_band(input logic [PHASE_W-1:0] w);
    if (w < BAND_LO) return BAND_LO;
    if (w > BAND_HI) return BAND_HI;
    return w;
  endfunction

  assign accept = req & ~busy;
  assign commit = busy & wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shad_word <= BAND_LO;
      shad_oct  <= '0;
      live_word <= BAND_LO;
      live_oct  <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      shad_word <= fit_band(req_word);
      shad_oct  <= req_oct;
    end else if (commit) begin
      busy      <= 1'b0;
      live_word <= shad_word;
      live_oct  <= shad_oct;
    end
  end

  // R5: an accepted request raises busy on the next edge
  assert_busy_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy)
    else $error("busy not raised");

  // R6: shadow values hold while busy
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(shad_word) && $stable(shad_oct)))
    else $error("shadow changed while busy");

  // R7: live settings change only as busy falls
  assert_live_at_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(live_word) || !$stable(live_oct)) |-> $fell(busy))
    else $error("live setting changed outside commit");
endmodule

// File: rtl/dds_octave_gen.sv
module dds_octave_gen
  import dds_octave_pkg::*;
#(
  parameter int unsigned PHASE_W = DEF_PHASE_W,
  parameter int unsigned OCT_W   = DEF_OCT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_req,
  input  logic [PHASE_W-1:0] tune_word,
  input  logic [OCT_W-1:0]   octave,
  output logic               busy,
  output logic               dds_clk,
  output logic               sq_out
);
  logic [PHASE_W-1:0] live_word;
  logic [OCT_W-1:0]   live_oct;
  logic               wrap_flip;
  logic               wrap_evt;

  dds_update_ctrl #(.PHASE_W(PHASE_W), .OCT_W(OCT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (upd_req),
    .req_word  (tune_word),
    .req_oct   (octave),
    .wrap_evt  (wrap_evt),
    .busy      (busy),
    .live_word (live_word),
    .live_oct  (live_oct)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_word (live_word),
    .msb_out   (dds_clk)
  );

  dds_octave_div #(.OCT_W(OCT_W)) u_div (
    .base_clk  (dds_clk),
    .rst_n     (rst_n),
    .oct_req   (live_oct),
    .div_out   (sq_out),
    .wrap_flip (wrap_flip)
  );

  dds_wrap_sync #(.STAGES(SYNC_FLOPS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .flip_in  (wrap_flip),
    .wrap_evt (wrap_evt)
  );

  // R9: outputs quiet in reset
  always_comb begin
    if (!rst_n) assert_quiet_reset_R9: assert (!busy && !sq_out)
      else $error("outputs active in reset");
  end
endmodule

// File: tb/dds_octave_gen_test.sv
module dds_octave_gen_test;
  localparam int CLK_NS = 10;
  localparam int PW = 24;
  localparam int OW = 4;
  localparam logic [PW-1:0] LO = 24'h200000;
  localparam logic [PW-1:0] HI = 24'h400000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd = 1'b0;
  logic [PW-1:0] tw = '0;
  logic [OW-1:0] oct = '0;
  logic          busy, dds_clk, sq;

  dds_octave_gen #(.PHASE_W(PW), .OCT_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .upd_req(upd), .tune_word(tw), .octave(oct),
    .busy(busy), .dds_clk(dds_clk), .sq_out(sq)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] band(input logic [PW-1:0] w);
    logic [PW-1:0] r;
    r = w;
    if (w > HI) r = HI;
    if (w < LO) r = LO;
    return r;
  endfunction

  // scoreboard queues
  logic [PW-1:0] q_tw[$];
  logic [OW-1:0] q_oct[$];
  bit            q_clamped[$];

  // monitor state
  bit            mon_on = 0;
  logic [PW-1:0] acc_m = '0;
  logic [PW-1:0] tw_m = LO;
  bit            tw_clamped = 0;
  int            cur_n = 0;
  int            next_n = 0;
  bit            armed = 0;
  int            msb_cnt = 0;
  bit            started = 0;
  int            last_rise = -100;
  int            exp_fall = -1;
  bit            await_rise = 0;
  logic          p_msb = 0, p_sq = 0, p_busy = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      acc_m = acc_m + tw_m;
      chk(dds_clk == acc_m[PW-1], tw_clamped ? "R2" : "R1", "phase msb",
          longint'(dds_clk), longint'(acc_m[PW-1]));
      if (dds_clk && !p_msb) msb_cnt++;
      if (sq && !p_sq) begin
        if (started) chk(msb_cnt == (1 << cur_n), armed ? "R8" : "R3",
                         "period in base edges", msb_cnt, 1 << cur_n);
        chk(dds_clk == 1'b1, "R3", "rise on base edge", dds_clk, 1);
        msb_cnt = 0;
        started = 1;
        last_rise = cyc;
        if (await_rise) begin exp_fall = cyc + 3; await_rise = 0; end
        if (armed) begin cur_n = next_n; armed = 0; end
      end
      if (!sq && p_sq && cur_n > 0)
        chk(msb_cnt == (1 << (cur_n - 1)), "R4", "high time", msb_cnt, 1 << (cur_n - 1));
      if (cur_n == 0) chk(sq == dds_clk, "R3", "undivided follows base", sq, dds_clk);
      if (busy && !p_busy) begin
        if (last_rise >= cyc - 2) exp_fall = last_rise + 3;
        else await_rise = 1;
      end
      if (!busy && p_busy) begin
        chk(cyc == exp_fall, "R7", "commit cycle", cyc, exp_fall);
        if (q_tw.size() == 0) begin
          chk(0, "R6", "commit without accepted request", 1, 0);
        end else begin
          tw_m = q_tw.pop_front();
          next_n = int'(q_oct.pop_front());
          tw_clamped = q_clamped.pop_front();
          armed = 1;
        end
        exp_fall = -1;
      end
      p_msb = dds_clk; p_sq = sq; p_busy = busy;
    end
  end

  task automatic issue(input logic [PW-1:0] w, input logic [OW-1:0] n, input int gap);
    repeat (gap) @(negedge clk);
    while (busy) @(negedge clk);
    q_tw.push_back(band(w));
    q_oct.push_back(n);
    q_clamped.push_back(band(w) != w);
    tw = w; oct = n; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk(busy == 1'b1, "R5", "busy after accept", busy, 1);
  endtask

  task automatic settle(input int n);
    while (busy) @(negedge clk);
    repeat (3 * (1 << n) * 9 + 20) @(negedge clk);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
      chk(sq == 1'b0, "R9", "sq_out in reset", sq, 0);
    end
    rst_n = 1'b1;
    @(posedge clk);
    mon_on = 1;
    repeat (60) @(negedge clk);

    issue(24'h2C0000, 4'd1, 0);  settle(1);
    issue(24'h3FFFFF, 4'd2, 3);  settle(2);
    issue(24'h100000, 4'd3, 1);  settle(3);   // below band, R2
    issue(24'hF00000, 4'd0, 2);  settle(0);   // above band, R2
    // R6: second request while busy is dropped
    issue(24'h333333, 4'd4, 0);
    tw = 24'h210000; oct = 4'd6; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk(busy == 1'b1, "R6", "busy held by ignored request", busy, 1);
    settle(4);
    // sweep request timing against output edges (R7, R8)
    for (int k = 0; k < 10; k++) begin
      issue(LO + PW'(k * 24'h33333), OW'(k % 3), k);
      settle(k % 3);
    end
    issue(HI, 4'd5, 1);  settle(5);
    chk(q_tw.size() == 0, "R7", "pending requests left", q_tw.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog expired actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule